// File: doc/BRIEF.md
# Register-Mapped Multiply / Divide / Accumulate Unit

This block is a small arithmetic engine that sits behind a byte-wide register write port. Software loads two 16-bit operands one byte at a time, picks an operation through a two-bit mode register, and reads a 40-bit result back as five byte registers. Three operations are offered: a single product, a quotient/remainder pair, and a running sum of products. A running sum spills into the upper eight guard bits, and a sticky flag records that spill.

Writing the high byte of the second operand is what launches the work, so a caller can rewrite any subset of operand bytes and only pay for an operation when the last byte lands. Products and running sums finish in the next cycle. A division by a non-zero divisor runs one bit per cycle and holds `busy` while it does. A zero divisor returns a fixed, defined answer at once. Throughout the operation every write is ignored and the visible result does not move.

Top module: `arith_unit`

## Requirements
- R1: After reset the result is zero, and `busy`, `done` and `overflow` are low.
- R2: `rdAddr` 0, 1, 2, 3 and 4 return result bits 7:0, 15:8, 23:16, 31:24 and 39:32. Addresses 5 to 7 return zero.
- R3: Write addresses are 0 mode, 1 operand A low byte, 2 operand A high byte, 3 operand B low byte, 4 operand B high byte. With mode 0 a write to address 4 sets the result to the unsigned 32-bit product A×B with bits 39:32 zero, and `done` is high in the next cycle only.
- R4: Writes to addresses 0 to 3 never start an operation: they leave the result unchanged and `done` low.
- R5: With mode 1 and a non-zero divisor, a write to address 4 raises `busy` in the next cycle for 16 cycles. In the cycle `busy` falls, `done` is high and the result holds the unsigned quotient in bits 15:0, the remainder in bits 31:16 and zero above.
- R6: With mode 1 and a zero divisor, the next cycle shows a result of A shifted left by 16 (quotient 0, remainder A), with `done` high and `busy` low.
- R7: With mode 2 or 3 a write to address 4 adds A×B to the 40-bit result, wrapping modulo 2^40, with `done` high in the next cycle.
- R8: `overflow` is set when an accumulate leaves any of result bits 39:32 non-zero, and stays set until a clear.
- R9: A mode write with bit 1 set zeroes the result and `overflow` in the next cycle without pulsing `done`. A mode write with bit 1 clear changes neither.
- R10: While `busy` is high, all writes are ignored: operands, mode, clear and trigger.
- R11: The readable result does not change while `busy` is high, except in the completing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write register select |
| wrData | input | 8 | Write data byte |
| rdAddr | input | 3 | Result byte select |
| rdData | output | 8 | Selected result byte, combinational from the result register |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when a new result is visible |
| overflow | output | 1 | Sticky accumulate spill flag |

## Verification
A product, a running sum, a zero-divisor answer and a clear are all visible one clock after the write edge that causes them. A real division shows its result, together with the `done` pulse, sixteen clocks after the trigger edge. `busy` stays high over the fifteen clocks in between, plus the first clock after the trigger. The bench model counts the same sixteen edges down with a plain integer. It holds its own copy of the result and compares the selected byte, `busy`, `done` and `overflow` two nanoseconds after every rising edge, so each expected value is checked in exactly the cycle it is due. `rdAddr` sweeps all eight codes continuously, so every result byte and the empty addresses are checked during idle, busy and completing cycles alike.

// File: rtl/arith_pkg.sv
package arith_pkg;
  localparam int BYTE_W    = 8;
  localparam int OP_W      = 2 * BYTE_W;
  localparam int GUARD_W   = 8;
  localparam int RES_W     = 2 * OP_W + GUARD_W;
  localparam int RES_BYTES = RES_W / BYTE_W;
  localparam int ADDR_W    = 3;
  localparam int STEP_W    = $clog2(OP_W);

  localparam logic [ADDR_W-1:0] ADR_MODE   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_A_LO   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_A_HI   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_B_LO   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADR_B_HI   = ADDR_W'(4);

  typedef enum logic [1:0] {
    MODE_MUL     = 2'd0,
    MODE_DIV     = 2'd1,
    MODE_ACC     = 2'd2,
    MODE_ACC_ALT = 2'd3
  } mode_e;

  typedef struct packed {
    logic ldALo;
    logic ldAHi;
    logic ldBLo;
    logic clearAcc;
    logic doMul;
    logic doAcc;
    logic doDivZero;
    logic divStart;
    logic divStep;
    logic divFinish;
  } strobe_t;
endpackage

// File: rtl/arith_ctrl.sv
module arith_ctrl
  import arith_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        modeIn,
  input  logic              opBZero,
  output strobe_t           strb,
  output logic              busy,
  output logic              done
);
  mode_e             modeQ;
  logic              busyQ;
  logic              doneQ;
  logic [STEP_W-1:0] stepQ;
  logic              accept;
  logic              ldMode;

  assign accept = wrEn && !busyQ;

  always_comb begin
    strb   = '0;
    ldMode = accept && (wrAddr == ADR_MODE);
    strb.ldALo    = accept && (wrAddr == ADR_A_LO);
    strb.ldAHi    = accept && (wrAddr == ADR_A_HI);
    strb.ldBLo    = accept && (wrAddr == ADR_B_LO);
    strb.clearAcc = ldMode && modeIn[1];
    if (accept && (wrAddr == ADR_B_HI)) begin
      case (modeQ)
        MODE_MUL: strb.doMul = 1'b1;
        MODE_DIV: begin
          if (opBZero) strb.doDivZero = 1'b1;
          else         strb.divStart  = 1'b1;
        end
        default:  strb.doAcc = 1'b1;
      endcase
    end
    strb.divStep   = busyQ;
    strb.divFinish = busyQ && (stepQ == STEP_W'(OP_W - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_MUL;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      stepQ <= '0;
    end else begin
      if (ldMode) modeQ <= mode_e'(modeIn);
      if (strb.divStart)       busyQ <= 1'b1;
      else if (strb.divFinish) busyQ <= 1'b0;
      if (strb.divStart)  stepQ <= '0;
      else if (busyQ)     stepQ <= stepQ + 1'b1;
      doneQ <= strb.doMul | strb.doAcc | strb.doDivZero | strb.divFinish;
    end
  end

  assign busy = busyQ;
  assign done = doneQ;
endmodule

// File: rtl/arith_dpath.sv
module arith_dpath
  import arith_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic [RES_W-1:0]  resultQ,
  output logic              overflowQ,
  output logic              opBZero
);
  logic [BYTE_W-1:0]  aLoQ, aHiQ, bLoQ;
  logic [OP_W-1:0]    opA, opB;
  logic [2*OP_W-1:0]  product;
  logic [RES_W-1:0]   accSum;
  logic [OP_W-1:0]    remQ, quoQ, dvsQ;
  logic [OP_W:0]      partial;
  logic [OP_W-1:0]    diff, remNext, quoNext;
  logic               fits;

  assign opA     = {aHiQ, aLoQ};
  assign opB     = {wrData, bLoQ};
  assign opBZero = (opB == '0);
  assign product = opA * opB;
  assign accSum  = resultQ + {{GUARD_W{1'b0}}, product};

  // one restoring-division step per cycle
  assign partial = {remQ, quoQ[OP_W-1]};
  assign fits    = partial >= {1'b0, dvsQ};
  assign diff    = partial[OP_W-1:0] - dvsQ;
  assign remNext = fits ? diff : partial[OP_W-1:0];
  assign quoNext = {quoQ[OP_W-2:0], fits};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aLoQ <= '0;
      aHiQ <= '0;
      bLoQ <= '0;
    end else begin
      if (strb.ldALo) aLoQ <= wrData;
      if (strb.ldAHi) aHiQ <= wrData;
      if (strb.ldBLo) bLoQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ <= '0;
      quoQ <= '0;
      dvsQ <= '0;
    end else if (strb.divStart) begin
      remQ <= '0;
      quoQ <= opA;
      dvsQ <= opB;
    end else if (strb.divStep) begin
      remQ <= remNext;
      quoQ <= quoNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ   <= '0;
      overflowQ <= 1'b0;
    end else begin
      if (strb.clearAcc) begin
        resultQ   <= '0;
        overflowQ <= 1'b0;
      end else if (strb.doMul) begin
        resultQ <= {{GUARD_W{1'b0}}, product};
      end else if (strb.doAcc) begin
        resultQ <= accSum;
        if (accSum[RES_W-1:2*OP_W] != '0) overflowQ <= 1'b1;
      end else if (strb.doDivZero) begin
        resultQ <= {{GUARD_W{1'b0}}, opA, {OP_W{1'b0}}};
      end else if (strb.divFinish) begin
        resultQ <= {{GUARD_W{1'b0}}, remNext, quoNext};
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < RES_BYTES; i++) begin
      if (rdAddr == ADDR_W'(i)) rdData = resultQ[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import arith_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              overflow
);
  strobe_t          strb;
  logic             opBZero;
  logic [RES_W-1:0] resultBus;

  arith_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .modeIn  (wrData[1:0]),
    .opBZero (opBZero),
    .strb    (strb),
    .busy    (busy),
    .done    (done)
  );

  arith_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .resultQ   (resultBus),
    .overflowQ (overflow),
    .opBZero   (opBZero)
  );
endmodule

// File: rtl/arith_unit_chk.sv
module arith_unit_chk
  import arith_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              clrBit,
  input logic              busy,
  input logic              done,
  input logic              overflow,
  input logic [RES_W-1:0]  resultQ
);
  logic trigWr, clrWr;
  assign trigWr = wrEn && (wrAddr == ADR_B_HI) && !busy;
  assign clrWr  = wrEn && (wrAddr == ADR_MODE) && clrBit && !busy;

  a_r4_trigger_answers: assert property (@(posedge clk) disable iff (!rstN)
    trigWr |=> (done || busy));

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(wrEn && wrAddr == ADR_B_HI)) |=> (!done && !busy));

  a_r5_done_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r11_result_held: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(resultQ) || done));

  a_r9_clear_effect: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> (resultQ == '0 && !overflow && !done));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overflow) |-> $past(clrWr));
endmodule

bind arith_unit arith_unit_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .clrBit   (wrData[1]),
  .busy     (busy),
  .done     (done),
  .overflow (overflow),
  .resultQ  (resultBus)
);

// File: tb/tb_arith_unit.sv
`timescale 1ns/1ps
module tb_arith_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       busy, done, overflow;

  arith_unit dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .done(done), .overflow(overflow)
  );

  always #5 clk = ~clk;

  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 1'b0;
  string curReq = "R1";

  // behavioural reference
  logic [39:0] mRes = '0, pend = '0;
  logic [15:0] mA = '0;
  logic [7:0]  mBLo = '0;
  logic [1:0]  mMode = '0;
  int          busyLeft = 0;
  bit          mDone = 1'b0, mOvf = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mRes = '0; mA = '0; mBLo = '0; mMode = '0; busyLeft = 0; mDone = 0; mOvf = 0;
    end else begin
      mDone = 0;
      if (busyLeft > 0) begin
        busyLeft = busyLeft - 1;
        if (busyLeft == 0) begin mRes = pend; mDone = 1; end
      end else if (wrEn) begin
        case (wrAddr)
          3'd0: begin
            mMode = wrData[1:0];
            if (wrData[1]) begin mRes = '0; mOvf = 0; end
          end
          3'd1: mA[7:0]  = wrData;
          3'd2: mA[15:8] = wrData;
          3'd3: mBLo     = wrData;
          3'd4: begin
            longint unsigned a, b;
            a = mA;
            b = {wrData, mBLo};
            if (mMode == 2'd0) begin
              mRes = 40'(a * b); mDone = 1;
            end else if (mMode == 2'd1) begin
              if (b == 0) begin mRes = 40'(a << 16); mDone = 1; end
              else begin pend = 40'(((a % b) << 16) | (a / b)); busyLeft = 16; end
            end else begin
              mRes = 40'(longint'(mRes) + a * b);
              if (mRes[39:32] != 0) mOvf = 1;
              mDone = 1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    logic [7:0] expRd;
    #2;
    expRd = (rdAddr < 3'd5) ? 8'(mRes >> (8 * rdAddr)) : 8'h00;
    vectors++;
    if (rdData !== expRd || busy !== (busyLeft > 0) || done !== mDone || overflow !== mOvf) begin
      miscompares++;
      $display("FAIL %s t=%0t rdAddr=%0d: rdData=%h exp %h busy=%b exp %b done=%b exp %b overflow=%b exp %b",
               curReq, $time, rdAddr, rdData, expRd, busy, (busyLeft > 0), done, mDone, overflow, mOvf);
    end
  end

  // sweep every read address continuously (R2)
  always @(negedge clk) rdAddr <= rdAddr + 3'd1;

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadOps(input logic [15:0] a, input logic [15:0] b);
    wr(3'd1, a[7:0]); wr(3'd2, a[15:8]); wr(3'd3, b[7:0]); wr(3'd4, b[15:8]);
  endtask

  initial begin
    curReq = "R1";
    idle(4);
    rstN = 1'b1;
    idle(8);

    curReq = "R3";
    wr(3'd0, 8'h00);
    loadOps(16'h1234, 16'h5678); idle(8);
    loadOps(16'hFFFF, 16'hFFFF); idle(8);
    curReq = "R2";
    idle(8);

    curReq = "R4";
    wr(3'd1, 8'h11); wr(3'd2, 8'h22); wr(3'd3, 8'h33); wr(3'd0, 8'h00); idle(8);

    curReq = "R5";
    wr(3'd0, 8'h01);
    loadOps(16'd1000, 16'd7);     idle(24);
    loadOps(16'hFFFF, 16'h0001);  idle(24);
    loadOps(16'h0005, 16'h0009);  idle(24);
    loadOps(16'hFFFF, 16'hFFFF);  idle(24);

    curReq = "R10";
    loadOps(16'hABCD, 16'h0123);
    wr(3'd4, 8'h00); wr(3'd1, 8'h55); wr(3'd0, 8'h03); wr(3'd3, 8'h00);
    idle(20);
    curReq = "R11";
    wr(3'd4, 8'h02); idle(24);

    curReq = "R6";
    loadOps(16'hBEEF, 16'h0000); idle(8);

    curReq = "R9";
    wr(3'd0, 8'h02); idle(4);
    curReq = "R7";
    loadOps(16'h1000, 16'h0010); idle(4);
    wr(3'd4, 8'h00); idle(4);
    curReq = "R8";
    loadOps(16'hFFFF, 16'hFFFF); idle(4);
    wr(3'd4, 8'hFF); idle(4);
    wr(3'd4, 8'hFF); idle(4);
    curReq = "R9";
    wr(3'd0, 8'h01); idle(8);
    wr(3'd0, 8'h03); idle(8);
    curReq = "R7";
    loadOps(16'h0003, 16'h0005); wr(3'd4, 8'h00); idle(8);

    curReq = "R3";
    wr(3'd0, 8'h00);
    @(negedge clk); wrEn = 1'b1; wrAddr = 3'd4; wrData = 8'h01;
    @(negedge clk); wrData = 8'h02;
    @(negedge clk); wrEn = 1'b0;
    idle(8);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule